// File: doc/BRIEF.md
# Disk Controller Command Register Interface

This block is the host side of a small hard-disk controller: a byte-wide register file reached through eight I/O ports, chosen by a three-bit port address. The host preloads two argument bytes and a sector number, then writes a command byte. The command takes effect on the clock edge that captures the write. Commands pick one of the drive units, load that unit's current cylinder or head, reset the status byte (rezero), or hand a sector transfer to the rest of the controller.

Each unit keeps its own cylinder and head, and the cylinder and head of the selected unit are brought out. A sector read or write command raises a one-cycle start strobe. The strobe carries the command byte and the sector number that was latched before the command. The sector buffer is outside this block. Accesses to the data port and to the buffer pointer reset port pass through as strobes. Data-port reads return a byte supplied from outside.

A write to argument port 0 also loads a diagnostic code into the error byte. An attach input marks the drive ready by clearing both the status and the error byte.

Top module: `disk_cmd_regif`

## Requirements
- R1: After reset the status byte (read port 7) is 0xD1, the error byte (read port 0) is 0x80, unit 0 is selected, and every unit's cylinder and head are 0.
- R2: A write to port 0 stores argument 0 and loads the error byte with 0x00 when the value written is 0x00, with 0x20 when it is 0x01, and with 0x30 for any other value.
- R3: Command 0x10 (written to port 2) selects the unit given by argument 0 bit 4. No other command or port write changes the selected unit.
- R4: Command 0x20 loads the selected unit's cylinder with argument 0 as the high byte and argument 1 as the low byte. The cylinder of the other unit is left unchanged.
- R5: Command 0x40 loads the selected unit's head from argument 1.
- R6: Command 0x80 (rezero) sets the status byte to 0xD1.
- R7: Command 0x81 (write sector) or 0x88 (read sector) makes startPulse high for exactly the one cycle after the command write. During that cycle startCode holds the command byte and startSector holds the last value written to port 3.
- R8: Command 0x00 and every command code not listed above change no unit, cylinder, head or status, and raise no start strobe.
- R9: Reads return the error byte at port 0 and the status byte at port 7. Ports 1 and 4 return bufRdData and raise bufRdStb while rdEn is high. Ports 2, 3, 5 and 6 return 0xFF.
- R10: A write to port 4 raises bufWrStb in the same cycle. A write to port 7 raises bufPtrClr and does not change the status byte.
- R11: An attach pulse clears the status and error bytes to 0x00. If attach coincides with a write to port 0 or a rezero command, attach wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| rdEn | input | 1 | Host read strobe |
| addr | input | 3 | Port address |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Read byte for the port on addr |
| attach | input | 1 | Drive attached, clears status and error |
| bufRdData | input | 8 | Byte from the sector buffer |
| bufRdStb | output | 1 | Data-port read strobe |
| bufWrStb | output | 1 | Data-port write strobe (byte on wrData) |
| bufPtrClr | output | 1 | Buffer pointer reset strobe |
| selUnit | output | 1 | Selected unit index |
| curCyl | output | 16 | Cylinder of the selected unit |
| curHead | output | 8 | Head of the selected unit |
| startPulse | output | 1 | Sector transfer start strobe |
| startCode | output | 8 | Command byte of the transfer |
| startSector | output | 8 | Sector number of the transfer |

## Verification
The bench builds the block with its defaults: two units, a 16-bit cylinder and an 8-bit head. These defaults put a cylinder with a non-zero high byte within reach. They also let the unit-select bit (argument 0 bit 4) toggle, so per-unit isolation can be checked by switching units back and forth. A queue-based scoreboard predicts each sector-start strobe with its code and sector. Strobes that were not predicted are caught, and so are strobes raised by no-op, unknown or rezero codes.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

  localparam int BYTE_W = 8;

  // port addresses
  localparam logic [2:0] PORT_ARG0   = 3'd0;
  localparam logic [2:0] PORT_ARG1   = 3'd1;
  localparam logic [2:0] PORT_CMD    = 3'd2;
  localparam logic [2:0] PORT_SEC    = 3'd3;
  localparam logic [2:0] PORT_DATA   = 3'd4;
  localparam logic [2:0] PORT_STATUS = 3'd7;

  // command codes
  localparam logic [7:0] CMD_NOP    = 8'h00;
  localparam logic [7:0] CMD_UNIT   = 8'h10;
  localparam logic [7:0] CMD_CYL    = 8'h20;
  localparam logic [7:0] CMD_HEAD   = 8'h40;
  localparam logic [7:0] CMD_REZERO = 8'h80;
  localparam logic [7:0] CMD_WRSEC  = 8'h81;
  localparam logic [7:0] CMD_RDSEC  = 8'h88;

  localparam logic [7:0] STATUS_RST = 8'hD1;
  localparam logic [7:0] ERROR_RST  = 8'h80;
  localparam logic [7:0] DIAG_ZERO  = 8'h00;
  localparam logic [7:0] DIAG_ONE   = 8'h20;
  localparam logic [7:0] DIAG_OTHER = 8'h30;
  localparam logic [7:0] OPEN_BUS   = 8'hFF;

  // strobes from control to datapath
  typedef struct packed {
    logic ldArg0;
    logic ldArg1;
    logic ldSec;
    logic setUnit;
    logic setCyl;
    logic setHead;
    logic rezero;
    logic startXfer;
  } dskcStrb_t;

  function automatic logic [7:0] diagCode(input logic [7:0] v);
    if (v == 8'h00)      return DIAG_ZERO;
    else if (v == 8'h01) return DIAG_ONE;
    else                 return DIAG_OTHER;
  endfunction

endpackage

// File: rtl/dskc_ctrl.sv
module dskc_ctrl
  import dskc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [7:0]  wrData,
  output dskcStrb_t   strb,
  output logic        bufWrStb,
  output logic        bufRdStb,
  output logic        bufPtrClr
);

  logic cmdWrite;

  always_comb begin
    cmdWrite       = wrEn && (addr == PORT_CMD);
    strb           = '0;
    strb.ldArg0    = wrEn && (addr == PORT_ARG0);
    strb.ldArg1    = wrEn && (addr == PORT_ARG1);
    strb.ldSec     = wrEn && (addr == PORT_SEC);
    if (cmdWrite) begin
      case (wrData)
        CMD_UNIT:             strb.setUnit   = 1'b1;
        CMD_CYL:              strb.setCyl    = 1'b1;
        CMD_HEAD:             strb.setHead   = 1'b1;
        CMD_REZERO:           strb.rezero    = 1'b1;
        CMD_WRSEC, CMD_RDSEC: strb.startXfer = 1'b1;
        default:              ; // no-op and unknown codes
      endcase
    end
    bufWrStb  = wrEn && (addr == PORT_DATA);
    bufPtrClr = wrEn && (addr == PORT_STATUS);
    bufRdStb  = rdEn && ((addr == PORT_DATA) || (addr == PORT_ARG1));
  end

  // at most one command action per write
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setUnit, strb.setCyl, strb.setHead, strb.rezero, strb.startXfer})); // R8

  AST_NOOP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == PORT_CMD && wrData == CMD_NOP) |-> (strb == '0)); // R8

endmodule

// File: rtl/dskc_datapath.sv
module dskc_datapath
  import dskc_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int UNIT_LSB  = 4,
  parameter int CYL_W     = 16,
  parameter int HEAD_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dskcStrb_t            strb,
  input  logic [7:0]           wrData,
  input  logic [2:0]           rdAddr,
  input  logic                 attach,
  input  logic [7:0]           bufRdData,
  output logic [7:0]           rdData,
  output logic [((NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1)-1:0] selUnit,
  output logic [CYL_W-1:0]     curCyl,
  output logic [HEAD_W-1:0]    curHead,
  output logic                 startPulse,
  output logic [7:0]           startCode,
  output logic [7:0]           startSector
);

  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

  logic [7:0]        arg0Reg, arg1Reg, secReg, statusReg, errReg;
  logic [UNIT_W-1:0] selReg;
  logic [CYL_W-1:0]  cylArr  [NUM_UNITS];
  logic [HEAD_W-1:0] headArr [NUM_UNITS];
  logic [15:0]       cylWord;

  assign cylWord = {arg0Reg, arg1Reg};

  // operand and sector registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arg0Reg <= '0;
      arg1Reg <= '0;
      secReg  <= '0;
    end else begin
      if (strb.ldArg0) arg0Reg <= wrData;
      if (strb.ldArg1) arg1Reg <= wrData;
      if (strb.ldSec)  secReg  <= wrData;
    end
  end

  // status and error bytes; attach has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= STATUS_RST;
      errReg    <= ERROR_RST;
    end else if (attach) begin
      statusReg <= '0;
      errReg    <= '0;
    end else begin
      if (strb.rezero) statusReg <= STATUS_RST;
      if (strb.ldArg0) errReg    <= diagCode(wrData);
    end
  end

  // unit selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             selReg <= '0;
    else if (strb.setUnit) selReg <= arg0Reg[UNIT_LSB +: UNIT_W];
  end

  // per-unit position registers
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic hit;
    assign hit = (selReg == UNIT_W'(u));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cylArr[u]  <= '0;
        headArr[u] <= '0;
      end else begin
        if (strb.setCyl && hit)  cylArr[u]  <= cylWord[CYL_W-1:0];
        if (strb.setHead && hit) headArr[u] <= arg1Reg[HEAD_W-1:0];
      end
    end
  end

  // transfer start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse  <= 1'b0;
      startCode   <= '0;
      startSector <= '0;
    end else begin
      startPulse <= strb.startXfer;
      if (strb.startXfer) begin
        startCode   <= wrData;
        startSector <= secReg;
      end
    end
  end

  // host read mux
  always_comb begin
    case (rdAddr)
      PORT_ARG0:            rdData = errReg;
      PORT_ARG1, PORT_DATA: rdData = bufRdData;
      PORT_STATUS:          rdData = statusReg;
      default:              rdData = OPEN_BUS;
    endcase
  end

  assign selUnit = selReg;
  assign curCyl  = cylArr[selReg];
  assign curHead = headArr[selReg];

  AST_ATTACH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    attach |=> (statusReg == 8'h00 && errReg == 8'h00)); // R11

  AST_REZERO_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rezero && !attach) |=> (statusReg == STATUS_RST)); // R6

  AST_UNIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setUnit |=> $stable(selReg)); // R3

  AST_START_CODE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (startCode == CMD_WRSEC || startCode == CMD_RDSEC)); // R7

  AST_DIAG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldArg0 && !attach) |=> (errReg == DIAG_ZERO || errReg == DIAG_ONE || errReg == DIAG_OTHER)); // R2

endmodule

// File: rtl/disk_cmd_regif.sv
module disk_cmd_regif
  import dskc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        attach,
  input  logic [7:0]  bufRdData,
  output logic        bufRdStb,
  output logic        bufWrStb,
  output logic        bufPtrClr,
  output logic        selUnit,
  output logic [15:0] curCyl,
  output logic [7:0]  curHead,
  output logic        startPulse,
  output logic [7:0]  startCode,
  output logic [7:0]  startSector
);

  dskcStrb_t strb;

  dskc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrData    (wrData),
    .strb      (strb),
    .bufWrStb  (bufWrStb),
    .bufRdStb  (bufRdStb),
    .bufPtrClr (bufPtrClr)
  );

  dskc_datapath #(
    .NUM_UNITS (2),
    .UNIT_LSB  (4),
    .CYL_W     (16),
    .HEAD_W    (8)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .rdAddr      (addr),
    .attach      (attach),
    .bufRdData   (bufRdData),
    .rdData      (rdData),
    .selUnit     (selUnit),
    .curCyl      (curCyl),
    .curHead     (curHead),
    .startPulse  (startPulse),
    .startCode   (startCode),
    .startSector (startSector)
  );

endmodule

// File: tb/disk_cmd_regif_bench.sv
`timescale 1ns/1ps
module disk_cmd_regif_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, attach = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0, bufRdData = 8'h5C;
  logic [7:0]  rdData, startCode, startSector, curHead;
  logic [15:0] curCyl;
  logic        bufRdStb, bufWrStb, bufPtrClr, selUnit, startPulse;

  int checks = 0;
  int failures = 0;

  typedef struct { logic [7:0] code; logic [7:0] sec; } startExp_t;
  startExp_t expQ[$];
  logic [7:0] secModel = 8'h00;

  always #5 clk = ~clk;

  disk_cmd_regif u_disk_cmd_regif (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .attach(attach), .bufRdData(bufRdData),
    .bufRdStb(bufRdStb), .bufWrStb(bufWrStb), .bufPtrClr(bufPtrClr),
    .selUnit(selUnit), .curCyl(curCyl), .curHead(curHead),
    .startPulse(startPulse), .startCode(startCode), .startSector(startSector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // driver: one host write, predicts start strobes
  task automatic wrPort(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    if (a == 3'd2 && (d == 8'h81 || d == 8'h88)) expQ.push_back('{d, secModel});
    if (a == 3'd3) secModel = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 3'd0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [7:0] exp, input bit expStb, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1;
    chkEq(tag, rdData, exp);
    chkEq({tag, " strobe"}, bufRdStb, expStb);
    rdEn = 1'b0;
  endtask

  task automatic pulseAttach();
    @(negedge clk); attach = 1'b1;
    @(negedge clk); attach = 1'b0;
  endtask

  // monitor: compare each start strobe with the queue head
  always @(negedge clk) begin
    if (rstN && startPulse) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected start strobe", {24'h0, startCode}, 32'h0);
      end else begin
        startExp_t e;
        e = expQ.pop_front();
        chkEq("R7 start code", startCode, e.code);
        chkEq("R7 start sector", startSector, e.sec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdChk(3'd7, 8'hD1, 1'b0, "R1 status after reset");
    rdChk(3'd0, 8'h80, 1'b0, "R1 error after reset");
    chkEq("R1 unit after reset", selUnit, 1'b0);
    chkEq("R1 cylinder after reset", curCyl, 16'h0);
    chkEq("R1 head after reset", curHead, 8'h0);

    // R2 diagnostic code
    wrPort(3'd0, 8'h00); rdChk(3'd0, 8'h00, 1'b0, "R2 arg0=00");
    wrPort(3'd0, 8'h01); rdChk(3'd0, 8'h20, 1'b0, "R2 arg0=01");
    wrPort(3'd0, 8'h5A); rdChk(3'd0, 8'h30, 1'b0, "R2 arg0=5A");
    wrPort(3'd0, 8'h88); rdChk(3'd0, 8'h30, 1'b0, "R2 arg0=88");

    // R11 attach clears
    wrPort(3'd0, 8'h01);
    pulseAttach();
    rdChk(3'd7, 8'h00, 1'b0, "R11 status after attach");
    rdChk(3'd0, 8'h00, 1'b0, "R11 error after attach");

    // R4 cylinder on unit 0
    wrPort(3'd0, 8'h01); wrPort(3'd1, 8'h2C); wrPort(3'd2, 8'h20);
    chkEq("R4 unit0 cylinder", curCyl, 16'h012C);
    // R3 select unit 1 by bit 4
    wrPort(3'd0, 8'h10); wrPort(3'd2, 8'h10);
    chkEq("R3 unit1 selected", selUnit, 1'b1);
    chkEq("R4 unit1 cylinder untouched", curCyl, 16'h0);
    wrPort(3'd0, 8'h03); wrPort(3'd1, 8'hFF); wrPort(3'd2, 8'h20);
    chkEq("R4 unit1 cylinder", curCyl, 16'h03FF);
    chkEq("R3 unit kept by arg0 write", selUnit, 1'b1);
    wrPort(3'd0, 8'hEF); wrPort(3'd2, 8'h10);
    chkEq("R3 unit0 via bit4 clear", selUnit, 1'b0);
    chkEq("R4 unit0 cylinder kept", curCyl, 16'h012C);

    // R5 head
    wrPort(3'd1, 8'h07); wrPort(3'd2, 8'h40);
    chkEq("R5 head", curHead, 8'h07);

    // R7 sector starts
    wrPort(3'd3, 8'h0B); wrPort(3'd2, 8'h88);
    wrPort(3'd3, 8'h22); wrPort(3'd2, 8'h81);
    @(negedge clk);
    chkEq("R7 strobe one cycle", startPulse, 1'b0);
    chkEq("R7 all starts seen", expQ.size(), 0);

    // R8 no-op and unknown codes
    foreach (expQ[i]) ;
    begin
      logic [7:0] codes [3] = '{8'h00, 8'h41, 8'h90};
      for (int i = 0; i < 3; i++) begin
        wrPort(3'd2, codes[i]);
        chkEq("R8 no start strobe", startPulse, 1'b0);
        chkEq("R8 cylinder kept", curCyl, 16'h012C);
        chkEq("R8 head kept", curHead, 8'h07);
        chkEq("R8 unit kept", selUnit, 1'b0);
        rdChk(3'd7, 8'h00, 1'b0, "R8 status kept");
      end
    end

    // R6 rezero
    wrPort(3'd2, 8'h80);
    chkEq("R6 no start strobe on rezero", startPulse, 1'b0);
    rdChk(3'd7, 8'hD1, 1'b0, "R6 status after rezero");

    // R9 read map
    rdChk(3'd2, 8'hFF, 1'b0, "R9 port2");
    rdChk(3'd3, 8'hFF, 1'b0, "R9 port3");
    rdChk(3'd5, 8'hFF, 1'b0, "R9 port5");
    rdChk(3'd6, 8'hFF, 1'b0, "R9 port6");
    rdChk(3'd4, 8'h5C, 1'b1, "R9 port4");
    bufRdData = 8'hA3;
    rdChk(3'd1, 8'hA3, 1'b1, "R9 port1");

    // R10 data and pointer strobes
    @(negedge clk); wrEn = 1'b1; addr = 3'd4; wrData = 8'h66; #1;
    chkEq("R10 data write strobe", bufWrStb, 1'b1);
    chkEq("R10 no pointer clear on data", bufPtrClr, 1'b0);
    @(negedge clk); addr = 3'd7; #1;
    chkEq("R10 pointer clear strobe", bufPtrClr, 1'b1);
    @(negedge clk); wrEn = 1'b0; addr = 3'd0;
    rdChk(3'd7, 8'hD1, 1'b0, "R10 status kept on port7 write");

    // R11 attach wins over arg0 write
    @(negedge clk); attach = 1'b1; wrEn = 1'b1; addr = 3'd0; wrData = 8'h01;
    @(negedge clk); attach = 1'b0; wrEn = 1'b0;
    rdChk(3'd0, 8'h00, 1'b0, "R11 attach over arg0");

    repeat (3) @(negedge clk);
    chkEq("R7 queue drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule